// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block turns one user request into the full command sequence for a single burst on a 32-bit SDRAM. A request carries a direction flag and a flat 23-bit word address. The address splits into three fields: the upper two bits give the bank, the next twelve bits give the row, and the low nine bits give the starting column. The sequencer issues ACTIVE with the bank and row. It holds NOPs for the row-to-column delay, then issues READ or WRITE with the column and auto-precharge off. It moves one burst of data. It then closes the bank with a PRECHARGE and waits out the precharge time before it takes another request.

Write data flows straight from the user port to the data pins, one word per cycle, in the cycles where `wr_take` is high. Read data is registered CAS-latency cycles after the READ and returned with a valid strobe. Each returned word is tagged with the column it came from, following the sequential or interleaved burst order chosen by the `burst_ilv` input. Burst length, CAS latency and the timing gaps are parameters, and they must match the device's programmed mode register. Device initialization and refresh are handled elsewhere.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is low, and after it until a request arrives, `req_ready` is 1, `rd_valid` is 0, `sd_dq_oe` is 0 and the command pins {cs_n,ras_n,cas_n,we_n} read NOP (4'b0111).
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle the pins carry ACTIVE (4'b0011) with `sd_ba` = addr[22:21] and `sd_a` = addr[20:9].
- R3: Exactly TRCD cycles after the ACTIVE cycle, the pins carry READ (4'b0101) or WRITE (4'b0100), matching `req_write`. This command has the same bank, `sd_a[8:0]` = addr[8:0] and `sd_a[10]` = 0.
- R4: Each request produces exactly one ACTIVE, one READ or WRITE and one PRECHARGE. Every other cycle carries NOP.
- R5: For a write, `wr_take` and `sd_dq_oe` are high for BL consecutive cycles starting in the WRITE cycle. In each of those cycles `sd_dq_out` equals `wr_data`. `sd_dq_oe` is low in all other cycles.
- R6: For a read, the word present on `sd_dq_in` CL+k cycles after the READ cycle (k = 0..BL-1) appears on `rd_data` with `rd_valid` high one cycle later. `rd_valid` is high for exactly BL cycles per read.
- R7: `rd_col` for beat k keeps the column bits above the burst and replaces the low log2(BL) bits. With `burst_ilv` = 0 they become (start + k) mod BL. With `burst_ilv` = 1 they become start XOR k.
- R8: PRECHARGE (4'b0010) to the same bank with `sd_a[10]` = 0 is issued BL cycles after a READ. After a WRITE it is issued BL-1+TWR cycles after the WRITE.
- R9: `req_ready` is low from ACTIVE until TRP cycles after PRECHARGE, when it returns high. A request held valid while busy starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved (change only while idle) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Flat address {bank, row, column} |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| wr_data | input | 32 | Write word for the current beat |
| wr_take | output | 1 | Current `wr_data` is consumed this cycle |
| rd_valid | output | 1 | `rd_data` / `rd_col` hold a read word |
| rd_data | output | 32 | Returned read word |
| rd_col | output | 9 | Column of the returned word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Row / column address lines |
| sd_dq_out | output | 32 | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data returned from the device |

## Verification
The hardest case to reach is a burst whose start column sits on the last word of its group, near the top of the column space. In that case the sequential order must wrap inside the group and never carry into the upper column bits. The interleaved order must instead reflect the start across the group. Directed requests place the start at column 511 and at mid-group columns under both orders. Random requests then flip the order between transactions. A second awkward case is a request held valid through the busy period with a changing address. The stimulus holds it and drops it exactly in the cycle ready returns, which shows that nothing was started early.

// File: rtl/sbs_pkg.sv
// Package: command encodings and sequencer states shared by the burst sequencer.
// Assumes command pins ordered {cs_n, ras_n, cas_n, we_n}.
package sbs_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_BURST,
        ST_WREC,
        ST_RP
    } seq_st_e;

endpackage

// File: rtl/sbs_colgen.sv
// Module: burst column generator.
// Computes the column of beat k of a burst from the start column.
// Sequential order wraps inside the BL-aligned group; interleaved order XORs the beat index.
// Assumes BL is a power of two and at least 2.
module sbs_colgen #(
    parameter int COL_W = 9,
    parameter int BL    = 4,
    localparam int LBW  = $clog2(BL)
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [LBW-1:0]   beat,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [LBW-1:0] low;

    // Low bits follow the selected burst order; upper bits are kept.
    always_comb begin
        if (ilv) low = start_col[LBW-1:0] ^ beat;
        else     low = start_col[LBW-1:0] + beat;
        col = {start_col[COL_W-1:LBW], low};
    end

endmodule

// File: rtl/sbs_rd_align.sv
// Module: read return aligner.
// Delays each read slot (valid + column) by CL cycles, then registers the device data.
// A slot in cycle r therefore yields rd_valid in cycle r+CL+1.
// Assumes CL >= 1.
module sbs_rd_align #(
    parameter int CL    = 2,
    parameter int COL_W = 9,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_vld,
    input  logic [COL_W-1:0] slot_col,
    input  logic [DW-1:0]    dq_in,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic [COL_W-1:0] rd_col
);

    logic             v_q [CL];
    logic [COL_W-1:0] c_q [CL];

    // Shift the slot markers along the CAS-latency delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CL; i++) begin
                v_q[i] <= 1'b0;
                c_q[i] <= '0;
            end
        end else begin
            for (int i = CL - 1; i > 0; i--) begin
                v_q[i] <= v_q[i-1];
                c_q[i] <= c_q[i-1];
            end
            v_q[0] <= slot_vld;
            c_q[0] <= slot_col;
        end
    end

    // Capture the device word when a delayed slot reaches the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_col   <= '0;
        end else begin
            rd_valid <= v_q[CL-1];
            if (v_q[CL-1]) begin
                rd_data <= dq_in;
                rd_col  <= c_q[CL-1];
            end
        end
    end

endmodule

// File: rtl/sbs_fsm.sv
// Module: command sequencer state machine.
// Takes one request, issues ACTIVE, waits TRCD, issues READ/WRITE, runs BL beats,
// waits write recovery on writes, issues PRECHARGE, and waits TRP before going idle.
// All command and address outputs are registered. Assumes TRCD, TRP, TWR >= 1 and BL >= 2.
module sbs_fsm
    import sbs_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int ROW_W = 12,
    parameter int COL_W = 9,
    parameter int BL    = 4,
    parameter int TRCD  = 2,
    parameter int TRP   = 2,
    parameter int TWR   = 2,
    localparam int AW   = BA_W + ROW_W + COL_W,
    localparam int LBW  = $clog2(BL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    output sd_cmd_e          cmd,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_a,
    output logic             wr_phase,
    output logic             rd_slot,
    output logic [LBW-1:0]   beat,
    output logic [COL_W-1:0] start_col
);

    localparam int M1   = (TRCD > BL) ? TRCD : BL;
    localparam int M2   = (TRP > TWR) ? TRP : TWR;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);

    seq_st_e         st;
    logic [CW-1:0]   cnt;
    logic            wr_q;

    // Sequence the commands and count the wait and burst cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            cmd       <= CMD_NOP;
            sd_ba     <= '0;
            sd_a      <= '0;
            wr_q      <= 1'b0;
            start_col <= '0;
        end else begin
            cmd <= CMD_NOP;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd       <= CMD_ACT;
                        sd_ba     <= req_addr[AW-1 -: BA_W];
                        sd_a      <= req_addr[COL_W +: ROW_W];
                        start_col <= req_addr[COL_W-1:0];
                        wr_q      <= req_write;
                        cnt       <= CW'(TRCD - 1);
                        st        <= ST_RCD;
                    end
                end
                ST_RCD: begin
                    if (cnt == '0) begin
                        cmd  <= wr_q ? CMD_WR : CMD_RD;
                        sd_a <= ROW_W'(start_col);
                        cnt  <= CW'(BL - 1);
                        st   <= ST_BURST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_BURST: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (wr_q && TWR > 1) begin
                        cnt <= CW'(TWR - 2);
                        st  <= ST_WREC;
                    end else begin
                        cmd  <= CMD_PRE;
                        sd_a <= '0;
                        cnt  <= CW'(TRP - 1);
                        st   <= ST_RP;
                    end
                end
                ST_WREC: begin
                    if (cnt == '0) begin
                        cmd  <= CMD_PRE;
                        sd_a <= '0;
                        cnt  <= CW'(TRP - 1);
                        st   <= ST_RP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RP: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode the phase strobes and the beat index from the state.
    always_comb begin
        req_ready = (st == ST_IDLE);
        wr_phase  = (st == ST_BURST) && wr_q;
        rd_slot   = (st == ST_BURST) && !wr_q;
        beat      = LBW'(CW'(BL - 1) - cnt);
    end

endmodule

// File: rtl/sdram_burst_seq.sv
// Module: SDRAM single-burst command sequencer (top).
// Maps a flat {bank,row,column} address onto ACTIVE / READ|WRITE / PRECHARGE, passes
// write data through during the write burst, and returns read data tagged with its column.
// Assumes the device mode register matches BL, CL and the burst order on burst_ilv.
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int BA_W  = 2,
    parameter int ROW_W = 12,
    parameter int COL_W = 9,
    parameter int BL    = 4,
    parameter int CL    = 2,
    parameter int TRCD  = 2,
    parameter int TRP   = 2,
    parameter int TWR   = 2,
    localparam int AW   = BA_W + ROW_W + COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_ilv,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_take,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic [COL_W-1:0] rd_col,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_a,
    output logic [DW-1:0]    sd_dq_out,
    output logic             sd_dq_oe,
    input  logic [DW-1:0]    sd_dq_in
);

    localparam int LBW = $clog2(BL);

    sd_cmd_e          cmd;
    logic             wr_phase;
    logic             rd_slot;
    logic [LBW-1:0]   beat;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] slot_col;

    sbs_fsm #(
        .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .BL(BL), .TRCD(TRCD), .TRP(TRP), .TWR(TWR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .cmd(cmd), .sd_ba(sd_ba), .sd_a(sd_a),
        .wr_phase(wr_phase), .rd_slot(rd_slot), .beat(beat), .start_col(start_col)
    );

    sbs_colgen #(.COL_W(COL_W), .BL(BL)) u_col (
        .start_col(start_col), .beat(beat), .ilv(burst_ilv), .col(slot_col)
    );

    sbs_rd_align #(.CL(CL), .COL_W(COL_W), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .slot_vld(rd_slot), .slot_col(slot_col), .dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col)
    );

    // Drive the command pins and the write data path.
    always_comb begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
        sd_dq_out = wr_data;
        sd_dq_oe  = wr_phase;
        wr_take   = wr_phase;
    end

endmodule

// File: rtl/sbs_checker.sv
// Module: protocol checker for sdram_burst_seq, attached by bind.
// Observes the top-level ports only.
module sbs_checker #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 12,
    parameter int COL_W = 9,
    localparam int AW   = BA_W + ROW_W + COL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [AW-1:0]    req_addr,
    input logic             req_ready,
    input logic             wr_take,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [BA_W-1:0]  sd_ba,
    input logic [ROW_W-1:0] sd_a
);

    logic [3:0] pins;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R2
    act_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (pins == 4'b0011 && sd_ba == $past(req_addr[AW-1 -: BA_W])
                                      && sd_a == $past(req_addr[COL_W +: ROW_W])));

    // R9
    busy_at_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0011) |-> !req_ready);

    // R9
    busy_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |=> !req_ready);

    // R3
    no_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0101 || pins == 4'b0100) |-> !sd_a[10]);

    // R5
    take_starts_at_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_take) |-> (pins == 4'b0100));

    // R8
    pre_single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> !sd_a[10]);

endmodule

bind sdram_burst_seq sbs_checker #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .wr_take(wr_take),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a)
);

// File: tb/sim_sdram_burst_seq.sv
`timescale 1ns/1ps
// Bench: drives directed and seeded random requests, models the device data bus,
// and checks command timing and data against bench-computed expectations.
module sim_sdram_burst_seq;

    localparam int BL = 4, CL = 2, TRCD = 2, TRP = 2, TWR = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_ilv = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic        req_ready;
    logic [31:0] wr_data = '0;
    logic        wr_take;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [8:0]  rd_col;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_a;
    logic [31:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [31:0] sd_dq_in = '0;

    always #2.5 clk = ~clk;

    sdram_burst_seq #(.BL(BL), .CL(CL), .TRCD(TRCD), .TRP(TRP), .TWR(TWR)) u0 (
        .clk(clk), .rst_n(rst_n), .burst_ilv(burst_ilv),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .wr_data(wr_data), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    int checks = 0, errors = 0, cyc = 0, txn = 0;
    bit done = 0;

    int act_cyc = -100, rw_cyc = -100, pre_cyc = -100, rdy_cyc = 0;
    int n_act = 0, n_rw = 0, n_pre = 0, wbeat = 0, rbeat = 0;
    logic [1:0]  act_ba, rw_ba, pre_ba;
    logic [11:0] act_row;
    logic [8:0]  rw_col;
    bit rw_wr = 0, rw_a10 = 0, pre_a10 = 0, rdy_prev = 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [8:0] colexp(input logic [8:0] s, input int k, input bit ilv);
        logic [8:0] m = 9'(BL - 1);
        logic [8:0] lo = ilv ? (s ^ 9'(k)) : (s + 9'(k));
        return (s & ~m) | (lo & m);
    endfunction

    function automatic logic [31:0] mword(input logic [1:0] b, input logic [11:0] r, input logic [8:0] c);
        logic [31:0] x = {9'd0, b, r, c};
        return (x * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] wword(input int t, input int k);
        return {16'(t), 8'hA5, 8'(k)};
    endfunction

    // Device-side monitor and data model, evaluated mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
                4'b0111: ;
                4'b0011: begin act_cyc = cyc; act_ba = sd_ba; act_row = sd_a; n_act++; end
                4'b0101, 4'b0100: begin
                    rw_cyc = cyc; rw_wr = !sd_we_n; rw_col = sd_a[8:0]; rw_ba = sd_ba;
                    rw_a10 = sd_a[10]; n_rw++; wbeat = 0; rbeat = 0;
                end
                4'b0010: begin pre_cyc = cyc; pre_ba = sd_ba; pre_a10 = sd_a[10]; n_pre++; end
                default: chk(0, "R4 illegal command", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
            endcase
            if (req_ready && !rdy_prev) rdy_cyc = cyc;
            rdy_prev = req_ready;
            // Device drives read beat k in cycle READ+CL+k (R6).
            if (n_rw > 0 && !rw_wr && cyc - rw_cyc >= CL && cyc - rw_cyc < CL + BL)
                sd_dq_in = mword(act_ba, act_row, colexp(rw_col, cyc - rw_cyc - CL, burst_ilv));
            else
                sd_dq_in = 32'hDEAD0000 ^ 32'(cyc);
            if (rd_valid) begin
                chk(!rw_wr && (cyc - rw_cyc - CL - 1) == rbeat, "R6 read beat timing",
                    32'(cyc - rw_cyc), 32'(CL + 1 + rbeat));
                chk(rd_data == mword(act_ba, act_row, colexp(rw_col, rbeat, burst_ilv)), "R6 read data",
                    rd_data, mword(act_ba, act_row, colexp(rw_col, rbeat, burst_ilv)));
                chk(rd_col == colexp(rw_col, rbeat, burst_ilv), "R7 read column order",
                    32'(rd_col), 32'(colexp(rw_col, rbeat, burst_ilv)));
                rbeat++;
            end
            if (wr_take) begin
                wr_data = wword(txn, wbeat);
                #1;
                chk(rw_wr && cyc == rw_cyc + wbeat, "R5 write beat timing", 32'(cyc - rw_cyc), 32'(wbeat));
                chk(sd_dq_oe && sd_dq_out == wr_data, "R5 write data on pins", sd_dq_out, wr_data);
                wbeat++;
            end else if (sd_dq_oe) begin
                chk(0, "R5 output enable outside burst", 32'd1, 32'd0);
            end
        end
    end

    task automatic run_txn(input bit wr, input logic [22:0] addr, input bit hold);
        int acc, a0, r0, p0;
        while (!req_ready) @(negedge clk);
        txn++;
        a0 = n_act; r0 = n_rw; p0 = n_pre;
        req_valid = 1; req_write = wr; req_addr = addr; acc = cyc;
        @(negedge clk);
        if (hold) begin req_addr = ~addr; req_write = ~wr; end
        else req_valid = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 0;
        repeat (CL + 2) @(negedge clk);
        chk(act_cyc == acc + 1, "R2 ACTIVE cycle", 32'(act_cyc), 32'(acc + 1));
        chk(act_ba == addr[22:21] && act_row == addr[20:9], "R2 bank/row", {18'd0, act_ba, act_row}, {18'd0, addr[22:9]});
        chk(rw_cyc == act_cyc + TRCD && rw_wr == wr, "R3 column command timing", 32'(rw_cyc - act_cyc), 32'(TRCD));
        chk(rw_ba == addr[22:21] && rw_col == addr[8:0] && !rw_a10, "R3 column/bank", {21'd0, rw_a10, rw_ba, rw_col}, {23'd0, addr[22:21], addr[8:0]});
        chk(n_act - a0 == 1 && n_rw - r0 == 1 && n_pre - p0 == 1, "R4 one command of each kind",
            32'((n_act - a0) * 100 + (n_rw - r0) * 10 + (n_pre - p0)), 32'd111);
        if (wr) chk(wbeat == BL, "R5 write beat count", 32'(wbeat), 32'(BL));
        else    chk(rbeat == BL, "R6 read beat count", 32'(rbeat), 32'(BL));
        chk(pre_cyc == (wr ? rw_cyc + BL - 1 + TWR : rw_cyc + BL), "R8 PRECHARGE timing",
            32'(pre_cyc - rw_cyc), 32'(wr ? BL - 1 + TWR : BL));
        chk(pre_ba == addr[22:21] && !pre_a10, "R8 PRECHARGE bank", {29'd0, pre_a10, pre_ba}, {30'd0, addr[22:21]});
        chk(rdy_cyc == pre_cyc + TRP, "R9 ready after TRP", 32'(rdy_cyc - pre_cyc), 32'(TRP));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(req_ready && !rd_valid && !sd_dq_oe && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111,
            "R1 reset state", {26'd0, req_ready, rd_valid, sd_dq_oe, sd_cs_n, sd_ras_n, sd_cas_n},
            {26'd0, 1'b1, 1'b0, 1'b0, 3'b011});
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rd_valid && !sd_dq_oe && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111,
            "R1 idle after reset", {31'd0, req_ready}, 32'd1);
        // Directed corners: top column, top row, both orders, held request.
        burst_ilv = 0;
        run_txn(1, {2'd3, 12'hFFF, 9'h1FF}, 0);
        run_txn(0, {2'd3, 12'hFFF, 9'h1FF}, 0);
        run_txn(0, {2'd2, 12'h800, 9'h006}, 0);
        burst_ilv = 1;
        run_txn(0, {2'd1, 12'd5, 9'd5}, 0);
        run_txn(0, {2'd0, 12'd0, 9'h1FF}, 0);
        run_txn(1, 23'd0, 1);
        run_txn(0, {2'd2, 12'h123, 9'h0A2}, 1);
        for (int i = 0; i < 40; i++) begin
            burst_ilv = 1'($urandom % 2);
            run_txn(1'($urandom % 2), 23'($urandom), ($urandom % 4) == 0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule